// File: doc/BRIEF.md
# Dual Clock Pair Selector with Retime Mute

This block sits between two incoming serial audio clock pairs and a set of DAC data lanes. Each pair has a bit clock and a frame clock. A select bit for each lane steers either pair 1 or pair 2 to that lane. A pin for stand-alone operation overrides every select bit and pins all lanes to pair 1.

The block measures the frame period of both pairs in master-clock cycles. It accepts the pairs as locked only when both periods have held steady for a number of consecutive frames and the longer period is a whole multiple of the shorter. Once locked, the block watches for a frame period that drifts outside a small tolerance or a frame edge that stops arriving. If either pair fails this way, both pairs and every lane go into one shared retime period. During that period the DAC-active flag drops, the lane clocks are held low, and every mute pin shows the level chosen by the mute polarity input. The retime period ends when the lock conditions are met again.

Pair 2 can be left unused, held static low. If no lane selects it, it is treated as absent rather than lost, and lock is taken on pair 1 alone.

Top module: `clk_pair_sel`

## Requirements
- R1: While locked and not in stand-alone mode, lane i carries pair 1 (bit and frame clock) when lane_sel[i] is 0 and pair 2 when lane_sel[i] is 1.
- R2: While locked with standalone high, every lane carries pair 1 whatever lane_sel holds.
- R3: After reset, and until lock is first reached, dac_active is 0.
- R4: mute_o shows mute_pol on every bit while dac_active is 0, and the inverse of mute_pol on every bit while dac_active is 1.
- R5: Lock is reached only after pair 1 (and pair 2, when it is in use) has shown LOCK_FRAMES consecutive frame periods that each lie within TOL cycles of the previous one, with the two periods in a whole-number ratio within TOL. Pairs in a 3:2 ratio never lock.
- R6: While locked, a pair-1 frame period more than TOL cycles away from the locked value, or a pair-1 frame edge that has not arrived by TOL cycles past the locked period, ends lock.
- R7: A loss on pair 2 while it is monitored ends lock for all lanes, even when no lane selects pair 2.
- R8: A pair 2 that has shown no frame edge for MAX_PER master cycles is absent. When no lane selects it, lock is taken on pair 1 alone. Selecting an absent pair 2, or pair 2 edges starting up again outside stand-alone mode, ends lock.
- R9: Frame-period changes within TOL cycles of the locked value do not end lock.
- R10: While dac_active is 0, all lane bit and frame clock outputs are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every measurement counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_a | input | 1 | Pair 1 bit clock |
| fclk_a | input | 1 | Pair 1 frame clock |
| bclk_b | input | 1 | Pair 2 bit clock |
| fclk_b | input | 1 | Pair 2 frame clock |
| lane_sel | input | LANES | Per-lane pair select: 0 = pair 1, 1 = pair 2 |
| standalone | input | 1 | Forces all lanes to pair 1 and ignores pair 2 |
| mute_pol | input | 1 | Level driven on the mute pins while muted |
| lane_bclk | output | LANES | Bit clock routed to each lane |
| lane_fclk | output | LANES | Frame clock routed to each lane |
| mute_o | output | LANES | Mute pin for each DAC pair |
| dac_active | output | 1 | High while the clock pairs are locked |

## Verification
The hardest state to reach is lock on pair 1 alone after pair 2 has stopped. Reaching it takes a loss on pair 2, then a full MAX_PER window of silence before pair 2 counts as absent, then a fresh run of steady pair-1 frames. The bench gets there by stopping the pair-2 generator with all lanes on pair 1 and waiting out that window. It then selects pair 2 while it is absent, and later restarts pair 2, to show that each of these events breaks lock. It also drives pairs in a 3:2 ratio and holds them long enough to show that lock never returns.

// File: rtl/clk_pair_sel.sv
module clk_pair_sel #(
  parameter int LANES       = 4,
  parameter int MAX_PER     = 2048,
  parameter int TOL         = 2,
  parameter int LOCK_FRAMES = 4
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             bclk_a,
  input  logic             fclk_a,
  input  logic             bclk_b,
  input  logic             fclk_b,
  input  logic [LANES-1:0] lane_sel,
  input  logic             standalone,
  input  logic             mute_pol,
  output logic [LANES-1:0] lane_bclk,
  output logic [LANES-1:0] lane_fclk,
  output logic [LANES-1:0] mute_o,
  output logic             dac_active
);
  localparam int CW = $clog2(MAX_PER + 1);
  localparam int SW = $clog2(LOCK_FRAMES + 1);
  localparam logic [CW-1:0] MAXC = CW'(MAX_PER);
  localparam logic [SW-1:0] LF   = SW'(LOCK_FRAMES);

  logic [2:0]    sy   [2];
  logic [CW-1:0] cnt  [2];
  logic [CW-1:0] prv  [2];
  logic [CW-1:0] lck  [2];
  logic [SW-1:0] stab [2];
  logic          mon_b;

  wire [1:0] fc = {fclk_b, fclk_a};
  wire [1:0] edg = {sy[1][1] & ~sy[1][2], sy[0][1] & ~sy[0][2]};

  function automatic logic near(input logic [CW-1:0] x, input logic [CW-1:0] y);
    return ((x > y) ? (x - y) : (y - x)) <= CW'(TOL);
  endfunction

  function automatic logic late(input logic [CW-1:0] c, input logic [CW-1:0] l);
    return {1'b0, c} > ({1'b0, l} + (CW+1)'(TOL));
  endfunction

  wire [LANES-1:0] eff = standalone ? '0 : lane_sel;
  wire use_b  = |eff;
  wire b_skip = standalone || (cnt[1] == MAXC && !use_b);

  wire [CW-1:0] big = (prv[0] > prv[1]) ? prv[0] : prv[1];
  wire [CW-1:0] sml = (prv[0] > prv[1]) ? prv[1] : prv[0];
  wire [CW-1:0] rem = (sml != '0) ? (big % sml) : '0;
  wire ratio_ok = (sml != '0) && ((rem <= CW'(TOL)) || ((sml - rem) <= CW'(TOL)));

  wire ready = (stab[0] == LF) && (b_skip || ((stab[1] == LF) && ratio_ok));

  wire lost_a = (edg[0] && !near(cnt[0], lck[0])) || late(cnt[0], lck[0]);
  wire lost_b = (edg[1] && !near(cnt[1], lck[1])) || late(cnt[1], lck[1]);
  wire drop = dac_active &&
              (lost_a || (!standalone && (mon_b ? lost_b : (edg[1] || use_b))));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        sy[p]   <= '0;
        cnt[p]  <= '0;
        prv[p]  <= '0;
        lck[p]  <= '0;
        stab[p] <= '0;
      end
      dac_active <= 1'b0;
      mon_b      <= 1'b0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        sy[p] <= {sy[p][1:0], fc[p]};
        if (edg[p]) begin
          cnt[p] <= CW'(1);
          prv[p] <= cnt[p];
          if (drop || cnt[p] == MAXC || !near(cnt[p], prv[p]))
            stab[p] <= '0;
          else if (stab[p] != LF)
            stab[p] <= stab[p] + SW'(1);
        end else begin
          if (cnt[p] != MAXC) cnt[p] <= cnt[p] + CW'(1);
          if (drop || cnt[p] == MAXC) stab[p] <= '0;
        end
      end
      if (drop) begin
        dac_active <= 1'b0;
      end else if (!dac_active && ready) begin
        dac_active <= 1'b1;
        lck[0]     <= prv[0];
        lck[1]     <= prv[1];
        mon_b      <= !b_skip;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_bclk[i] = dac_active & (eff[i] ? bclk_b : bclk_a);
    assign lane_fclk[i] = dac_active & (eff[i] ? fclk_b : fclk_a);
  end

  assign mute_o = {LANES{dac_active ? ~mute_pol : mute_pol}};

  a_r5_lock_after_stable: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(dac_active) |-> $past(stab[0]) == LF);

  a_r6_late_edge_drops: assert property (@(posedge mclk) disable iff (!rst_n)
    (dac_active && late(cnt[0], lck[0])) |=> !dac_active);

  a_r8_absent_selected: assert property (@(posedge mclk) disable iff (!rst_n)
    (dac_active && !mon_b && use_b) |=> !dac_active);

  a_r10_quiet_in_retime: assert property (@(posedge mclk) disable iff (!rst_n)
    !dac_active |-> (lane_bclk == '0 && lane_fclk == '0));

  a_r2_standalone_pair1: assert property (@(posedge mclk) disable iff (!rst_n)
    (dac_active && standalone) |-> (lane_bclk == {LANES{bclk_a}} && lane_fclk == {LANES{fclk_a}}));
endmodule

// File: tb/clk_pair_sel_tb_top.sv
module clk_pair_sel_tb_top;
  localparam int LANES = 4;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_a = 1'b0, fclk_a = 1'b0, bclk_b = 1'b0, fclk_b = 1'b0;
  logic [LANES-1:0] lane_sel = '0;
  logic standalone = 1'b0;
  logic mute_pol = 1'b1;
  logic [LANES-1:0] lane_bclk, lane_fclk, mute_o;
  logic dac_active;

  int per_a = 64, per_b = 128, ca = 0, cb = 0;
  logic en_b = 1'b1;
  int checks = 0, fails = 0;

  always #2.5 mclk = ~mclk;

  clk_pair_sel #(.LANES(LANES)) dut_i (
    .mclk(mclk), .rst_n(rst_n),
    .bclk_a(bclk_a), .fclk_a(fclk_a), .bclk_b(bclk_b), .fclk_b(fclk_b),
    .lane_sel(lane_sel), .standalone(standalone), .mute_pol(mute_pol),
    .lane_bclk(lane_bclk), .lane_fclk(lane_fclk), .mute_o(mute_o),
    .dac_active(dac_active)
  );

  always @(negedge mclk) begin
    ca = (ca >= per_a - 1) ? 0 : ca + 1;
    fclk_a = (ca < per_a / 2);
    bclk_a = ca[1];
    if (en_b) begin
      cb = (cb >= per_b - 1) ? 0 : cb + 1;
      fclk_b = (cb < per_b / 2);
      bclk_b = cb[2];
    end else begin
      cb = 0;
      fclk_b = 1'b0;
      bclk_b = 1'b0;
    end
  end

  // {standalone, mute_pol, lane_sel[3:0], expected pair-2 lanes[3:0]}
  localparam logic [9:0] VEC [6] = '{
    10'b0_1_0000_0000,
    10'b0_0_1111_1111,
    10'b0_1_1010_1010,
    10'b0_0_0101_0101,
    10'b1_1_1111_0000,
    10'b1_0_0110_0000
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge mclk);
    #1;
  endtask

  task automatic check_route(input logic [3:0] pb, input string req);
    int bad = 0;
    logic [3:0] eb, ef;
    for (int s = 0; s < 24; s++) begin
      wait_cyc(1);
      for (int i = 0; i < LANES; i++) begin
        eb[i] = pb[i] ? bclk_b : bclk_a;
        ef[i] = pb[i] ? fclk_b : fclk_a;
      end
      if (lane_bclk !== eb || lane_fclk !== ef || dac_active !== 1'b1) begin
        bad++;
        if (bad == 1) $display("  route mismatch bclk=%b exp=%b fclk=%b exp=%b", lane_bclk, eb, lane_fclk, ef);
      end
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge mclk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_cyc(5);
    check(dac_active === 1'b0, "R3 active in reset", dac_active, 0);
    check(mute_o === 4'hF, "R4 mute level in reset", mute_o, 4'hF);
    check(lane_bclk === 4'h0 && lane_fclk === 4'h0, "R10 lanes quiet in reset", lane_bclk, 0);
    rst_n = 1'b1;
    wait_cyc(200);
    check(dac_active === 1'b0, "R3 no early lock", dac_active, 0);
    wait_cyc(2800);
    check(dac_active === 1'b1, "R5 lock with both pairs", dac_active, 1);

    for (int v = 0; v < 6; v++) begin
      standalone = VEC[v][9];
      mute_pol   = VEC[v][8];
      lane_sel   = VEC[v][7:4];
      wait_cyc(4);
      check_route(VEC[v][3:0], standalone ? "R2 standalone routing" : "R1 lane routing");
      check(mute_o === {LANES{~mute_pol}}, "R4 mute released", mute_o, {LANES{~mute_pol}});
    end
    standalone = 1'b0;
    lane_sel = '0;
    mute_pol = 1'b1;

    per_a = 65;
    wait_cyc(600);
    check(dac_active === 1'b1, "R9 small drift kept", dac_active, 1);
    per_a = 64;
    wait_cyc(300);

    per_a = 72;
    wait_cyc(300);
    check(dac_active === 1'b0, "R6 pair1 shift drops", dac_active, 0);
    check(mute_o === 4'hF, "R4 mute during retime", mute_o, 4'hF);
    check(lane_bclk === 4'h0 && lane_fclk === 4'h0, "R10 lanes quiet in retime", lane_bclk, 0);
    per_a = 64;
    wait_cyc(3000);
    check(dac_active === 1'b1, "R5 relock", dac_active, 1);

    per_b = 96;
    wait_cyc(400);
    check(dac_active === 1'b0, "R7 pair2 shift drops", dac_active, 0);
    wait_cyc(4000);
    check(dac_active === 1'b0, "R5 3:2 ratio never locks", dac_active, 0);
    per_b = 128;
    wait_cyc(3000);
    check(dac_active === 1'b1, "R5 relock after ratio fix", dac_active, 1);

    en_b = 1'b0;
    wait_cyc(400);
    check(dac_active === 1'b0, "R7 pair2 stop drops all lanes", dac_active, 0);
    wait_cyc(4000);
    check(dac_active === 1'b1, "R8 lock on pair1 alone", dac_active, 1);
    check_route(4'h0, "R8 lanes on pair1 with pair2 absent");
    lane_sel = 4'b0001;
    wait_cyc(10);
    check(dac_active === 1'b0, "R8 selecting absent pair2 drops", dac_active, 0);
    lane_sel = '0;
    wait_cyc(1000);
    check(dac_active === 1'b1, "R8 relock pair1 alone", dac_active, 1);
    en_b = 1'b1;
    wait_cyc(300);
    check(dac_active === 1'b0, "R8 pair2 restart drops", dac_active, 0);
    wait_cyc(3000);
    check(dac_active === 1'b1, "R5 lock with pair2 back", dac_active, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule